// File: doc/BRIEF.md
# Paged Ring Write Address Generator

This block produces the packet-memory write address for a receive DMA that stores frames into a ring of fixed-size pages. The address is formed by joining a page register, which supplies the upper bits, with a byte counter, which supplies the lower bits. With the default parameters the page register is 12 bits wide and the byte counter is 8 bits wide, so each page holds 256 bytes and the address is 20 bits wide.

Each accepted write strobe moves the byte counter forward by one. When a page is full, the counter returns to zero and the page register moves to the next page. If the page that just filled is the ring's upper boundary page, the next page is the ring's base page instead. The block makes this wrap only when the base page is marked free. If it is not free, the block stalls and ignores write strobes until the page is released.

A synchronous load places the page register at a chosen start page and clears the byte counter. The DMA engine that owns the ring uses it at the start of operation.

Top module: `ring_page_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and both `page_done_o` and `stall_o` are low.
- R2: `addr_o` is always the page register in bits [19:8] joined with the byte counter in bits [7:0]. A cycle with `load_i` high sets the page register to `start_page_i` and clears the byte counter, and the new address is visible after that clock edge.
- R3: A beat is accepted when `beat_i` is high, `load_i` is low and `stall_o` is low. An accepted beat raises `addr_o[7:0]` by one. In a cycle with no accepted beat, no load and no stall, `addr_o` does not change.
- R4: When a beat is accepted while `addr_o[7:0]` is 255 and the page is not the boundary page, `addr_o[7:0]` becomes 0 and the page becomes the current page plus one.
- R5: `page_done_o` is high for exactly one cycle, and that cycle is the one that follows the clock edge that accepted the last beat of a page.
- R6: When the last beat of the boundary page (page equal to `bound_page_i`) is accepted and `base_free_i` is high, the next address is `{base_page_i, 8'h00}`.
- R7: When the last beat of the boundary page is accepted and `base_free_i` is low, `stall_o` goes high after that edge. While stalled, `addr_o` holds its value and beats have no effect.
- R8: A stall ends at the first edge where `base_free_i` is high. After that edge `stall_o` is low and `addr_o` equals `{base_page_i, 8'h00}`.
- R9: `load_i` takes priority over a beat in the same cycle, and a load also clears a stall.
- R10: A page that is not the boundary page increments modulo 2^12, so page 0xFFF is followed by page 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the start page and clear the byte counter |
| start_page_i | input | 12 | Page used by a load |
| beat_i | input | 1 | Write strobe, one data byte |
| bound_page_i | input | 12 | Ring upper boundary page |
| base_page_i | input | 12 | Ring base page, the target of a wrap |
| base_free_i | input | 1 | Base page is free to be written |
| addr_o | output | 20 | Packet-memory write address |
| page_done_o | output | 1 | One-cycle pulse after a page fills |
| stall_o | output | 1 | Waiting for the base page to become free |

## Verification
Every result is registered once, so a load, a beat, a page change, the `page_done_o` pulse, stall entry and stall release each show at the outputs after the first rising edge that samples the cause. The bench changes inputs on falling edges and samples on the next falling edge. That places each check half a period after the one edge that produces the result. In the pulse and stall checks, the bench also samples one cycle later to confirm that `page_done_o` has dropped and that a stall has held its state.

// File: rtl/ring_addr_pkg.sv
`timescale 1ns/1ps
package ring_addr_pkg;
  localparam int unsigned PAGE_W_DEF = 12;
  localparam int unsigned OFF_W_DEF  = 8;

  typedef enum logic [0:0] {
    ST_RUN   = 1'b0,
    ST_STALL = 1'b1
  } ring_state_e;
endpackage

// File: rtl/ring_byte_ctr.sv
`timescale 1ns/1ps
module ring_byte_ctr #(
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [OFF_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [OFF_W-1:0] ONE = {{(OFF_W-1){1'b0}}, 1'b1};

  logic [OFF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + ONE; // natural rollover at page end
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;
endmodule

// File: rtl/ring_page_next.sv
`timescale 1ns/1ps
module ring_page_next #(
  parameter int unsigned PAGE_W = 12
) (
  input  logic [PAGE_W-1:0] cur_i,
  input  logic [PAGE_W-1:0] bound_i,
  output logic              at_bound_o,
  output logic [PAGE_W-1:0] inc_o
);
  localparam logic [PAGE_W-1:0] ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

  assign at_bound_o = (cur_i == bound_i);
  assign inc_o      = cur_i + ONE;
endmodule

// File: rtl/ring_wrap_ctl.sv
`timescale 1ns/1ps
module ring_wrap_ctl
  import ring_addr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic beat_i,
  input  logic last_i,
  input  logic at_bound_i,
  input  logic base_free_i,
  output logic accept_o,
  output logic adv_o,
  output logic wrap_o,
  output logic stall_o,
  output logic done_o
);
  ring_state_e state_q, state_d;
  logic        done_q;
  logic        page_end;

  assign accept_o = beat_i && !load_i && (state_q == ST_RUN);
  assign page_end = accept_o && last_i;
  assign adv_o    = page_end && !at_bound_i;
  assign wrap_o   = (page_end && at_bound_i && base_free_i) ||
                    ((state_q == ST_STALL) && !load_i && base_free_i);

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:   if (page_end && at_bound_i && !base_free_i) state_d = ST_STALL;
        ST_STALL: if (base_free_i) state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= page_end;
    end
  end

  assign stall_o = (state_q == ST_STALL);
  assign done_o  = done_q;
endmodule

// File: rtl/ring_page_addr_gen.sv
`timescale 1ns/1ps
module ring_page_addr_gen
  import ring_addr_pkg::*;
#(
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned OFF_W  = OFF_W_DEF,
  localparam int unsigned ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic              beat_i,
  input  logic [PAGE_W-1:0] bound_page_i,
  input  logic [PAGE_W-1:0] base_page_i,
  input  logic              base_free_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              page_done_o,
  output logic              stall_o
);
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_inc;
  logic [OFF_W-1:0]  off;
  logic              off_last;
  logic              at_bound;
  logic              accept, adv, wrap;

  ring_byte_ctr #(.OFF_W(OFF_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .inc_i  (accept),
    .cnt_o  (off),
    .last_o (off_last)
  );

  ring_page_next #(.PAGE_W(PAGE_W)) u_next (
    .cur_i      (page_q),
    .bound_i    (bound_page_i),
    .at_bound_o (at_bound),
    .inc_o      (page_inc)
  );

  ring_wrap_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .beat_i      (beat_i),
    .last_i      (off_last),
    .at_bound_i  (at_bound),
    .base_free_i (base_free_i),
    .accept_o    (accept),
    .adv_o       (adv),
    .wrap_o      (wrap),
    .stall_o     (stall_o),
    .done_o      (page_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= '0;
    else if (load_i)  page_q <= start_page_i;
    else if (wrap)    page_q <= base_page_i;
    else if (adv)     page_q <= page_inc;
  end

  assign addr_o = {page_q, off};
endmodule

// File: rtl/ring_page_addr_gen_chk.sv
`timescale 1ns/1ps
module ring_page_addr_gen_chk #(
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned OFF_W  = 8,
  localparam int unsigned ADDR_W = PAGE_W + OFF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [PAGE_W-1:0] start_page_i,
  input logic              beat_i,
  input logic [PAGE_W-1:0] bound_page_i,
  input logic [PAGE_W-1:0] base_page_i,
  input logic              base_free_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              page_done_o,
  input logic              stall_o
);
  logic acc;
  logic last_beat;
  assign acc       = beat_i && !load_i && !stall_o;
  assign last_beat = acc && (&addr_o[OFF_W-1:0]);

  AST_LOAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == {$past(start_page_i), {OFF_W{1'b0}}}) && !stall_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !beat_i && !stall_o) |=> $stable(addr_o)); // R3
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !(&addr_o[OFF_W-1:0])) |=> (addr_o == $past(addr_o) + 1'b1)); // R3
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_beat && addr_o[ADDR_W-1:OFF_W] != bound_page_i)
      |=> (addr_o[ADDR_W-1:OFF_W] == $past(addr_o[ADDR_W-1:OFF_W]) + 1'b1) && (addr_o[OFF_W-1:0] == '0)); // R4
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> page_done_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_done_o |=> !page_done_o); // R5
  AST_WRAP_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_beat && addr_o[ADDR_W-1:OFF_W] == bound_page_i && base_free_i)
      |=> (addr_o == {$past(base_page_i), {OFF_W{1'b0}}}) && !stall_o); // R6
  AST_STALL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_beat && addr_o[ADDR_W-1:OFF_W] == bound_page_i && !base_free_i) |=> stall_o); // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !load_i && !base_free_i) |=> stall_o && $stable(addr_o)); // R7
  AST_STALL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !load_i && base_free_i)
      |=> !stall_o && (addr_o == {$past(base_page_i), {OFF_W{1'b0}}})); // R8
endmodule

bind ring_page_addr_gen ring_page_addr_gen_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (load_i),
  .start_page_i (start_page_i),
  .beat_i       (beat_i),
  .bound_page_i (bound_page_i),
  .base_page_i  (base_page_i),
  .base_free_i  (base_free_i),
  .addr_o       (addr_o),
  .page_done_o  (page_done_o),
  .stall_o      (stall_o)
);

// File: tb/ring_page_addr_gen_bench.sv
`timescale 1ns/1ps
module ring_page_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [11:0] start_page = '0;
  logic        beat = 1'b0;
  logic [11:0] bound_page = 12'h020;
  logic [11:0] base_page = 12'h004;
  logic        base_free = 1'b1;
  logic [19:0] addr;
  logic        page_done;
  logic        stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ring_page_addr_gen u_ring_page_addr_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_i       (load),
    .start_page_i (start_page),
    .beat_i       (beat),
    .bound_page_i (bound_page),
    .base_page_i  (base_page),
    .base_free_i  (base_free),
    .addr_o       (addr),
    .page_done_o  (page_done),
    .stall_o      (stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [11:0] pg);
    @(negedge clk);
    start_page = pg; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // n beats, leaves the bench on the negedge after the last accepting edge
  task automatic beats(input int n);
    @(negedge clk);
    beat = 1'b1;
    repeat (n) @(negedge clk);
    beat = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 addr", addr, 0);
    chk("R1 page_done", page_done, 0);
    chk("R1 stall", stall, 0);
  endtask

  task automatic t_load;
    do_load(12'h123);
    chk("R2 load addr", addr, 20'h12300);
    chk("R2 no stall", stall, 0);
  endtask

  task automatic t_count;
    beats(3);
    chk("R3 three beats", addr, 20'h12303);
    repeat (2) @(negedge clk);
    chk("R3 idle hold", addr, 20'h12303);
    beats(1);
    chk("R3 single beat", addr, 20'h12304);
  endtask

  task automatic t_page_step;
    bound_page = 12'h020;
    do_load(12'h010);
    beats(255);
    chk("R4 before end", addr, 20'h010FF);
    chk("R5 no early pulse", page_done, 0);
    beats(1);
    chk("R4 next page", addr, 20'h01100);
    chk("R5 pulse", page_done, 1);
    @(negedge clk);
    chk("R5 pulse ends", page_done, 0);
  endtask

  task automatic t_wrap_free;
    base_page = 12'h004; base_free = 1'b1;
    do_load(12'h020);
    beats(256);
    chk("R6 wrap addr", addr, 20'h00400);
    chk("R6 no stall", stall, 0);
    chk("R5 pulse at wrap", page_done, 1);
  endtask

  task automatic t_wrap_stall;
    base_page = 12'h007; base_free = 1'b0;
    do_load(12'h020);
    beats(256);
    chk("R7 stall set", stall, 1);
    chk("R7 addr at stall", addr, 20'h02000);
    beats(3);
    chk("R7 beats ignored", addr, 20'h02000);
    chk("R7 still stalled", stall, 1);
    @(negedge clk);
    base_free = 1'b1;
    @(negedge clk);
    chk("R8 stall cleared", stall, 0);
    chk("R8 base addr", addr, 20'h00700);
  endtask

  task automatic t_load_prio;
    @(negedge clk);
    start_page = 12'h0AB; load = 1'b1; beat = 1'b1;
    @(negedge clk);
    load = 1'b0; beat = 1'b0;
    chk("R9 load beats beat", addr, 20'h0AB00);
    base_free = 1'b0;
    do_load(12'h020);
    beats(256);
    chk("R9 stalled first", stall, 1);
    do_load(12'h055);
    chk("R9 load clears stall", stall, 0);
    chk("R9 load addr", addr, 20'h05500);
    base_free = 1'b1;
  endtask

  task automatic t_top_page;
    bound_page = 12'h020;
    do_load(12'hFFF);
    beats(256);
    chk("R10 page wraps modulo", addr, 20'h00000);
    chk("R10 no stall", stall, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_count();
    t_page_step();
    t_wrap_free();
    t_wrap_stall();
    t_load_prio();
    t_top_page();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule